// File: doc/BRIEF.md
# Multiplexed Dual-Register Keystream Generator

This block produces one keystream bit per enabled clock from two maximal-length Fibonacci shift registers with coprime lengths. A fixed group of T stages of the first register is read as a T-bit address. A one-to-one table turns that address into a stage number of the second register. The content of that stage becomes the keystream bit. Both registers then advance together.

Software or a key-setup block seeds both registers with a load strobe. A seed of all zeros in either register would lock that register, so such a load is refused and an error flag is raised. Once a load is accepted, every enabled cycle yields one valid keystream bit. Register lengths, feedback taps, address stages and the mapping table are elaboration parameters. An elaboration-time check rejects a table that repeats a value or points past the second register.

Top module: `mxg_keystream`

## Requirements
- R1: During and right after reset, `ks_valid`, `ks_bit` and `seed_err` are 0, and no keystream is produced until a load is accepted.
- R2: A load with both seeds nonzero copies `seed_a` into the first register and `seed_b` into the second register. On the next cycle `seed_err` is 0 and `ks_valid` is 0.
- R3: A load with `seed_a` or `seed_b` equal to zero is refused. `seed_err` is 1 on the next cycle and stays 1 until the next accepted load or reset. Both registers keep their previous contents, and a block that has never been loaded stays unloaded.
- R4: On each enabled, non-load cycle after an accepted load, both registers shift toward the higher stage. The new bit enters stage 0 and is the XOR of the tapped stages. With the defaults (lengths 7 and 11), the first register uses taps 6 and 5 and the second uses taps 10 and 8.
- R5: The address is formed from the first register's current stages. By default, address bit 0 is stage 0, bit 1 is stage 3 and bit 2 is stage 6.
- R6: The default table maps addresses 0 to 7 onto second-register stages 2, 7, 0, 10, 5, 9, 3 and 8. `ks_bit` after an enabled edge equals the named stage of the second register as it stood before that edge.
- R7: `ks_valid` is 1 exactly in the cycle after an enabled, non-load edge of a loaded block. In every other cycle it is 0 and `ks_bit` holds its value.
- R8: When `load` and `en` are both high, the load wins. No bit is produced that cycle and the registers take the seeds.
- R9: At elaboration, the table must have no repeated entry and every entry must be below the second register's length. In addition, 2^T must not exceed that length, the address stages must lie inside the first register, and the two lengths must be coprime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Seed load strobe |
| seed_a | input | LEN_A | Seed for the address register |
| seed_b | input | LEN_B | Seed for the data register |
| en | input | 1 | Step enable |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | Keystream bit is new this cycle |
| seed_err | output | 1 | Last load was refused because of a zero seed |

## Verification
The in-line assertions check on every cycle that:
- the registers hold when neither stepped nor loaded,
- a register never reaches the all-zero state,
- a zero-seed load raises the error flag,
- an accepted load clears the flag,
- a valid bit always traces back to an enabled, non-load edge, and the bit holds otherwise.

Only the bench's scenarios can show that the produced bits match the tap, address and table definitions over more than a full period of the first register. They also show that a refused load truly leaves the stream undisturbed and that load wins over enable.

// File: rtl/mxg_pkg.sv
package mxg_pkg;

    localparam int unsigned IDX_W = 8;

    typedef enum logic [1:0] {
        MX_IDLE,
        MX_LOAD,
        MX_REJECT,
        MX_STEP
    } mx_cmd_e;

    typedef struct packed {
        logic bit_o;
        logic valid;
    } ks_out_t;

    function automatic mx_cmd_e decode_cmd(
        input logic load,
        input logic zero_a,
        input logic zero_b,
        input logic en,
        input logic loaded
    );
        if (load)
            return (zero_a || zero_b) ? MX_REJECT : MX_LOAD;
        else if (en && loaded)
            return MX_STEP;
        else
            return MX_IDLE;
    endfunction

endpackage

// File: rtl/mxg_lfsr.sv
module mxg_lfsr #(
    parameter int unsigned LEN = 7,
    parameter logic [LEN-1:0] TAPS = 7'b1100000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [LEN-1:0] seed,
    output logic [LEN-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst)
            state <= LEN'(1);
        else if (load)
            state <= seed;
        else if (step)
            state <= {state[LEN-2:0], ^(state & TAPS)};
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(state));

    assert_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/mxg_select.sv
module mxg_select
    import mxg_pkg::*;
#(
    parameter int unsigned LEN_A = 7,
    parameter int unsigned LEN_B = 11,
    parameter int unsigned T = 3,
    parameter logic [IDX_W*T-1:0] ADDR_IDX = {8'd6, 8'd3, 8'd0},
    parameter logic [IDX_W*(2**T)-1:0] MAP = {8'd8, 8'd3, 8'd9, 8'd5, 8'd10, 8'd0, 8'd7, 8'd2}
) (
    input  logic [LEN_A-1:0] reg_a,
    input  logic [LEN_B-1:0] reg_b,
    output logic [T-1:0]     addr,
    output logic             bit_o
);

    localparam int unsigned BW = $clog2(LEN_B);

    logic [IDX_W-1:0] entry;
    logic [BW-1:0]    stage;

    for (genvar k = 0; k < T; k++) begin : g_addr
        localparam int unsigned POS = int'(ADDR_IDX[IDX_W*k +: IDX_W]);
        assign addr[k] = reg_a[POS];
    end

    always_comb begin
        entry = MAP[IDX_W*int'(addr) +: IDX_W];
        stage = entry[BW-1:0];
        bit_o = reg_b[stage];
    end

endmodule

// File: rtl/mxg_keystream.sv
module mxg_keystream
    import mxg_pkg::*;
#(
    parameter int unsigned LEN_A = 7,
    parameter int unsigned LEN_B = 11,
    parameter logic [LEN_A-1:0] TAPS_A = 7'b1100000,
    parameter logic [LEN_B-1:0] TAPS_B = 11'b10100000000,
    parameter int unsigned T = 3,
    parameter logic [IDX_W*T-1:0] ADDR_IDX = {8'd6, 8'd3, 8'd0},
    parameter logic [IDX_W*(2**T)-1:0] MAP = {8'd8, 8'd3, 8'd9, 8'd5, 8'd10, 8'd0, 8'd7, 8'd2}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_A-1:0] seed_a,
    input  logic [LEN_B-1:0] seed_b,
    input  logic             en,
    output logic             ks_bit,
    output logic             ks_valid,
    output logic             seed_err
);

    localparam int unsigned ENTRIES = 2 ** T;

    mx_cmd_e          cmd;
    logic             loaded;
    ks_out_t          out_q;
    logic [LEN_A-1:0] reg_a;
    logic [LEN_B-1:0] reg_b;
    logic [T-1:0]     addr;
    logic             sel_bit;

    function automatic bit params_ok();
        bit ok = 1'b1;
        int unsigned x = LEN_A;
        int unsigned y = LEN_B;
        int unsigned r;
        if (ENTRIES > LEN_B) ok = 1'b0;
        for (int i = 0; i < T; i++)
            if (int'(ADDR_IDX[IDX_W*i +: IDX_W]) >= LEN_A) ok = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (int'(MAP[IDX_W*i +: IDX_W]) >= LEN_B) ok = 1'b0;
            for (int j = i + 1; j < ENTRIES; j++)
                if (MAP[IDX_W*i +: IDX_W] == MAP[IDX_W*j +: IDX_W]) ok = 1'b0;
        end
        while (y != 0) begin
            r = x % y;
            x = y;
            y = r;
        end
        if (x != 1) ok = 1'b0;
        return ok;
    endfunction

    initial begin
        assert_table_ok_R9: assert (params_ok())
            else $error("mapping table or register parameters invalid");
    end

    always_comb cmd = decode_cmd(load, seed_a == '0, seed_b == '0, en, loaded);

    mxg_lfsr #(.LEN(LEN_A), .TAPS(TAPS_A)) u_reg_a (
        .clk(clk), .rst(rst),
        .load(cmd == MX_LOAD), .step(cmd == MX_STEP),
        .seed(seed_a), .state(reg_a)
    );

    mxg_lfsr #(.LEN(LEN_B), .TAPS(TAPS_B)) u_reg_b (
        .clk(clk), .rst(rst),
        .load(cmd == MX_LOAD), .step(cmd == MX_STEP),
        .seed(seed_b), .state(reg_b)
    );

    mxg_select #(
        .LEN_A(LEN_A), .LEN_B(LEN_B), .T(T),
        .ADDR_IDX(ADDR_IDX), .MAP(MAP)
    ) u_select (
        .reg_a(reg_a), .reg_b(reg_b), .addr(addr), .bit_o(sel_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded   <= 1'b0;
            seed_err <= 1'b0;
            out_q    <= '0;
        end else begin
            out_q.valid <= 1'b0;
            unique case (cmd)
                MX_LOAD: begin
                    loaded   <= 1'b1;
                    seed_err <= 1'b0;
                end
                MX_REJECT: seed_err <= 1'b1;
                MX_STEP: out_q <= '{bit_o: sel_bit, valid: 1'b1};
                default: ;
            endcase
        end
    end

    assign ks_bit   = out_q.bit_o;
    assign ks_valid = out_q.valid;

    assert_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (load && (seed_a == '0 || seed_b == '0)) |=> seed_err);

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (load && seed_a != '0 && seed_b != '0) |=> (!seed_err && !ks_valid));

    assert_valid_src_R7: assert property (@(posedge clk) disable iff (rst)
        ks_valid |-> $past(en && !load));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(en && !load) |=> (!ks_valid && $stable(ks_bit)));

endmodule

// File: tb/mxg_keystream_tb_top.sv
module mxg_keystream_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [6:0]  seed_a = '0;
    logic [10:0] seed_b = '0;
    logic        en = 1'b0;
    logic        ks_bit, ks_valid, seed_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [6:0]  m_a;
    logic [10:0] m_b;
    int mapv [8] = '{2, 7, 0, 10, 5, 9, 3, 8};

    always #10 clk = ~clk;

    mxg_keystream dut_i (
        .clk(clk), .rst(rst), .load(load), .seed_a(seed_a), .seed_b(seed_b),
        .en(en), .ks_bit(ks_bit), .ks_valid(ks_valid), .seed_err(seed_err)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int exp_bit();
        int a = {m_a[6], m_a[3], m_a[0]};
        return int'(m_b[mapv[a]]);
    endfunction

    task automatic model_step();
        m_a = {m_a[5:0], m_a[6] ^ m_a[5]};
        m_b = {m_b[9:0], m_b[10] ^ m_b[8]};
    endtask

    task automatic stream(input int n, input string req);
        en = 1'b1;
        for (int i = 0; i < n; i++) begin
            int e = exp_bit();
            tick();
            check(req, ks_valid, 1);
            check(req, ks_bit, e);
            model_step();
        end
        en = 1'b0;
    endtask

    task automatic do_load(input logic [6:0] a, input logic [10:0] b);
        load = 1'b1; seed_a = a; seed_b = b;
        tick();
        load = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        check("R1 valid", ks_valid, 0);
        check("R1 bit", ks_bit, 0);
        check("R1 err", seed_err, 0);
        rst = 1'b0;
        en = 1'b1;
        tick(); tick();
        check("R1 no stream unloaded", ks_valid, 0);
        en = 1'b0;
    endtask

    task automatic t_reject_unloaded();
        do_load(7'd0, 11'd5);
        check("R3 err", seed_err, 1);
        en = 1'b1;
        tick(); tick();
        check("R3 still unloaded", ks_valid, 0);
        check("R3 err sticky", seed_err, 1);
        en = 1'b0;
    endtask

    task automatic t_run(input logic [6:0] a, input logic [10:0] b, input int n);
        do_load(a, b);
        check("R2 err cleared", seed_err, 0);
        check("R2 no valid", ks_valid, 0);
        m_a = a; m_b = b;
        stream(n, "R4 R6 stream");
    endtask

    task automatic t_reject_midstream();
        load = 1'b1; en = 1'b1; seed_a = 7'h15; seed_b = 11'd0;
        tick();
        load = 1'b0;
        check("R3 err mid", seed_err, 1);
        check("R3 no bit on reject", ks_valid, 0);
        stream(20, "R3 state kept");
    endtask

    task automatic t_hold();
        int last;
        tick();
        last = ks_bit;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R7 valid low", ks_valid, 0);
            check("R7 bit held", ks_bit, last);
        end
    endtask

    task automatic t_priority();
        load = 1'b1; en = 1'b1; seed_a = 7'h2A; seed_b = 11'h3C5;
        tick();
        load = 1'b0; en = 1'b0;
        check("R8 no bit", ks_valid, 0);
        m_a = 7'h2A; m_b = 11'h3C5;
        stream(10, "R8 new seeds");
    endtask

    task automatic t_addr();
        do_load(7'b0000001, 11'b00010000000);
        en = 1'b1; tick(); en = 1'b0;
        check("R5 addr1 picks stage7", ks_bit, 1);
        do_load(7'b0000001, 11'b11101111111);
        en = 1'b1; tick(); en = 1'b0;
        check("R5 addr1 stage7 zero", ks_bit, 0);
        do_load(7'b1001000, 11'b01000000000);
        en = 1'b1; tick(); en = 1'b0;
        check("R6 addr6 picks stage3", ks_bit, 0);
        do_load(7'b1001000, 11'b00000001000);
        en = 1'b1; tick(); en = 1'b0;
        check("R6 addr6 stage3 one", ks_bit, 1);
    endtask

    initial begin
        t_reset();
        t_reject_unloaded();
        t_run(7'h01, 11'h001, 300);
        t_reject_midstream();
        t_hold();
        t_run(7'h7F, 11'h7FF, 140);
        t_priority();
        t_addr();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule